// File: doc/BRIEF.md
# Clock multiplier setup controller

This block sits beside the protocol engine of a network controller and owns its clock setup. A small host port writes a setup register. That register holds a two-bit rate-select field, an enhanced-mode enable, a no-sync enable and a fast-read-timing enable. The block drives an enable to an external clock multiplier and a run signal to the protocol engine. It also reports the rate select in use.

After a hardware reset the engine runs from the base clock and the multiplier is powered down. When a setup write changes the rate select to a legal new value, the block does three things on the next edge: it halts the engine, loads the new rate and wakes the multiplier. Only one such change is granted per reset. The engine stays halted until the host writes the restart byte 0x18 to the command address, and that write counts only once the multiplier reports lock. A restart attempted before lock is dropped and leaves a sticky flag. The double rate also needs enhanced mode: without it, a configuration-error flag is raised and the engine is kept stopped.

Top module: `clk_mult_setup`

## Requirements
- R1: After reset, rateSel=00, enhOn=0, noSyncOn=0, rdFastTiming=0, mulEnable=0, cfgErr=0, earlyRestart=0 and coreRun=1.
- R2: mulEnable rises on the clock edge that accepts a change to the double-rate code 01, and it stays 0 until some change has been accepted.
- R3: An accepted rate-select change drops coreRun from the first edge after the setup write.
- R4: The halt ends only on a command-address (address 0) write of 0x18 made while mulLock=1. coreRun then returns on the next edge, unless cfgErr holds it low.
- R5: Only one rate-select change is accepted per reset. Later writes of a different legal code leave rateSel unchanged.
- R6: The setup register is at address 1, with rate select in bits [1:0], enhanced mode in bit 2, no-sync in bit 3 and fast-read timing in bit 4. Bits 2 to 4 update on every setup write. A read of address 1 returns these fields with the upper bits zero. A read of any other address returns 0.
- R7: rdFastTiming is 1 only when the fast-read bit is 1 and a read strobe is present without a write strobe. It is 0 during any write.
- R8: cfgErr is 1 exactly while rateSel=01 and enhanced mode is 0. While cfgErr is 1, coreRun is 0.
- R9: A 0x18 command that arrives while the engine is halted and mulLock=0 is ignored and sets earlyRestart. earlyRestart then stays 1 until reset.
- R10: A setup write whose rate-select code is 10 or 11 leaves rateSel unchanged, does not halt the engine and does not use up the one change.
- R11: A setup write with the rate-select code already in use does not halt the engine and does not use up the one change.
- R12: Command writes other than 0x18, and 0x18 while the engine is not halted, have no effect on coreRun or earlyRestart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host register address (0 command, 1 setup) |
| hostWrData | input | DATA_W | Host write data |
| hostRdData | output | DATA_W | Host read data, combinational by default |
| mulLock | input | 1 | Lock indication from the clock multiplier |
| mulEnable | output | 1 | Wakes the clock multiplier |
| coreRun | output | 1 | Run enable for the protocol engine |
| rateSel | output | 2 | Rate select in use |
| enhOn | output | 1 | Enhanced mode bit |
| noSyncOn | output | 1 | No-sync bit |
| rdFastTiming | output | 1 | Fast read timing active for the current read |
| cfgErr | output | 1 | Double rate selected without enhanced mode |
| earlyRestart | output | 1 | Sticky: restart tried before lock |

## Verification
Some properties hold on every cycle, and the assertions check those: a reserved code never reaches rateSel, and once the single change is used rateSel never moves. A halt always ends on a locked 0x18 command. A configuration error always stops the engine, the early-restart flag is sticky, and a write never shows fast read timing. Other behaviour depends on ordered stimulus and only the bench's scenarios show it. These are the rejected reserved and same-value writes, which leave the change unused so that a later change is still honoured. They also include early versus locked restarts against the lock model's delay, and a configuration error that persists through a restart and then clears when enhanced mode is written.

// File: rtl/clk_mult_setup_pkg.sv
package clk_mult_setup_pkg;

  localparam int SEL_W      = 2;
  localparam int FLD_SEL_LO = 0;
  localparam int FLD_ENH    = 2;
  localparam int FLD_NOSYNC = 3;
  localparam int FLD_FAST   = 4;
  localparam int FLD_MSB    = FLD_FAST;

  localparam logic [SEL_W-1:0] SEL_BASE   = 2'b00;
  localparam logic [SEL_W-1:0] SEL_DOUBLE = 2'b01;

  typedef enum logic [1:0] {
    ST_FRESH   = 2'd0,
    ST_HALTED  = 2'd1,
    ST_SETTLED = 2'd2
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadSel;
    logic haltSet;
    logic haltClr;
    logic earlyHit;
  } ctrlStrobe_t;

endpackage

// File: rtl/clk_mult_setup_regs.sv
module clk_mult_setup_regs
  import clk_mult_setup_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int SETUP_ADDR    = 1,
  parameter int CMD_ADDR      = 0,
  parameter int RESTART_CMD   = 8'h18,
  parameter bit RD_REGISTERED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  ctrlStrobe_t       strobe,
  output logic              setupWr,
  output logic              restartWr,
  output logic [SEL_W-1:0]  reqSel,
  output logic [SEL_W-1:0]  curSel,
  output logic              enhBit,
  output logic              noSyncBit,
  output logic              fastBit,
  output logic [DATA_W-1:0] hostRdData,
  output logic              rdFastTiming
);

  localparam logic [ADDR_W-1:0] SETUP_A = ADDR_W'(SETUP_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A   = ADDR_W'(CMD_ADDR);
  localparam logic [DATA_W-1:0] RST_CMD = DATA_W'(RESTART_CMD);

  logic              setupRd;
  logic [DATA_W-1:0] regImage;
  logic [DATA_W-1:0] rdNext;

  // Write decode
  always_comb begin
    setupWr   = hostWrEn && (hostAddr == SETUP_A);
    restartWr = hostWrEn && (hostAddr == CMD_A) && (hostWrData == RST_CMD);
    reqSel    = hostWrData[FLD_SEL_LO +: SEL_W];
    setupRd   = hostRdEn && (hostAddr == SETUP_A);
  end

  // Rate select: loaded only when control grants the change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSel <= SEL_BASE;
    end else if (strobe.loadSel) begin
      curSel <= reqSel;
    end
  end

  // Mode bits: updated on every setup write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enhBit    <= 1'b0;
      noSyncBit <= 1'b0;
      fastBit   <= 1'b0;
    end else if (setupWr) begin
      enhBit    <= hostWrData[FLD_ENH];
      noSyncBit <= hostWrData[FLD_NOSYNC];
      fastBit   <= hostWrData[FLD_FAST];
    end
  end

  // Fast read timing applies to reads only
  assign rdFastTiming = fastBit && hostRdEn && !hostWrEn;

  // Readback image
  always_comb begin
    regImage = '0;
    regImage[FLD_SEL_LO +: SEL_W] = curSel;
    regImage[FLD_ENH]    = enhBit;
    regImage[FLD_NOSYNC] = noSyncBit;
    regImage[FLD_FAST]   = fastBit;
    rdNext = setupRd ? regImage : '0;
  end

  generate
    if (RD_REGISTERED) begin : g_rdReg
      logic [DATA_W-1:0] rdQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rdQ <= '0;
        else       rdQ <= rdNext;
      end
      assign hostRdData = rdQ;
    end else begin : g_rdComb
      assign hostRdData = rdNext;
    end
  endgenerate

endmodule

// File: rtl/clk_mult_setup_ctrl.sv
module clk_mult_setup_ctrl
  import clk_mult_setup_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             setupWr,
  input  logic             restartWr,
  input  logic [SEL_W-1:0] reqSel,
  input  logic [SEL_W-1:0] curSel,
  input  logic             enhBit,
  input  logic             mulLock,
  output ctrlStrobe_t      strobe,
  output logic             halted,
  output logic             changeUsed,
  output logic             mulEnable,
  output logic             cfgErr,
  output logic             earlyRestart,
  output logic             coreRun
);

  ctrlState_e state, stateNext;
  logic       selLegal;
  logic       selDiffers;
  logic       acceptChange;

  always_comb begin
    // Codes with the top bit set are reserved
    selLegal     = !reqSel[SEL_W-1];
    selDiffers   = (reqSel != curSel);
    acceptChange = setupWr && selLegal && selDiffers && (state == ST_FRESH);

    strobe.loadSel  = acceptChange;
    strobe.haltSet  = acceptChange;
    strobe.haltClr  = restartWr && (state == ST_HALTED) && mulLock;
    strobe.earlyHit = restartWr && (state == ST_HALTED) && !mulLock;

    stateNext = state;
    unique case (state)
      ST_FRESH:   if (strobe.haltSet) stateNext = ST_HALTED;
      ST_HALTED:  if (strobe.haltClr) stateNext = ST_SETTLED;
      ST_SETTLED: stateNext = ST_SETTLED;
      default:    stateNext = ST_FRESH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_FRESH;
      mulEnable    <= 1'b0;
      earlyRestart <= 1'b0;
    end else begin
      state <= stateNext;
      if (acceptChange) mulEnable <= (reqSel != SEL_BASE);
      if (strobe.earlyHit) earlyRestart <= 1'b1;
    end
  end

  always_comb begin
    halted     = (state == ST_HALTED);
    changeUsed = (state != ST_FRESH);
    cfgErr     = (curSel == SEL_DOUBLE) && !enhBit;
    coreRun    = !halted && !cfgErr;
  end

endmodule

// File: rtl/clk_mult_setup.sv
module clk_mult_setup
  import clk_mult_setup_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int SETUP_ADDR    = 1,
  parameter int CMD_ADDR      = 0,
  parameter int RESTART_CMD   = 8'h18,
  parameter bit RD_REGISTERED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              mulLock,
  output logic              mulEnable,
  output logic              coreRun,
  output logic [1:0]        rateSel,
  output logic              enhOn,
  output logic              noSyncOn,
  output logic              rdFastTiming,
  output logic              cfgErr,
  output logic              earlyRestart
);

  ctrlStrobe_t      strobe;
  logic             setupWr;
  logic             restartWr;
  logic [SEL_W-1:0] reqSel;
  logic [SEL_W-1:0] curSel;
  logic             enhBit;
  logic             noSyncBit;
  logic             fastBit;
  logic             halted;
  logic             changeUsed;

  clk_mult_setup_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_ADDR(SETUP_ADDR),
    .CMD_ADDR(CMD_ADDR), .RESTART_CMD(RESTART_CMD), .RD_REGISTERED(RD_REGISTERED)
  ) regs_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .strobe(strobe),
    .setupWr(setupWr), .restartWr(restartWr), .reqSel(reqSel), .curSel(curSel),
    .enhBit(enhBit), .noSyncBit(noSyncBit), .fastBit(fastBit),
    .hostRdData(hostRdData), .rdFastTiming(rdFastTiming)
  );

  clk_mult_setup_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .setupWr(setupWr), .restartWr(restartWr),
    .reqSel(reqSel), .curSel(curSel), .enhBit(enhBit), .mulLock(mulLock),
    .strobe(strobe), .halted(halted), .changeUsed(changeUsed),
    .mulEnable(mulEnable), .cfgErr(cfgErr), .earlyRestart(earlyRestart),
    .coreRun(coreRun)
  );

  assign rateSel  = curSel;
  assign enhOn    = enhBit;
  assign noSyncOn = noSyncBit;

endmodule

// File: rtl/clk_mult_setup_chk.sv
module clk_mult_setup_chk #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int SETUP_ADDR  = 1,
  parameter int CMD_ADDR    = 0,
  parameter int RESTART_CMD = 8'h18
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWrEn,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWrData,
  input logic              mulLock,
  input logic              mulEnable,
  input logic              coreRun,
  input logic [1:0]        rateSel,
  input logic              rdFastTiming,
  input logic              cfgErr,
  input logic              earlyRestart,
  input logic              halted,
  input logic              changeUsed
);

  localparam logic [ADDR_W-1:0] SETUP_A = ADDR_W'(SETUP_ADDR);
  localparam logic [ADDR_W-1:0] CMD_A   = ADDR_W'(CMD_ADDR);
  localparam logic [DATA_W-1:0] RST_CMD = DATA_W'(RESTART_CMD);

  logic freshChangeWr;
  logic lockedRestartWr;
  assign freshChangeWr   = hostWrEn && (hostAddr == SETUP_A) && !hostWrData[1]
                           && (hostWrData[1:0] != rateSel) && !changeUsed;
  assign lockedRestartWr = hostWrEn && (hostAddr == CMD_A) && (hostWrData == RST_CMD) && mulLock;

  AST_MUL_OFF_UNTIL_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    !changeUsed |-> !mulEnable); // R2
  AST_CHANGE_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    freshChangeWr |=> !coreRun); // R3
  AST_RESTART_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(halted) |-> $past(lockedRestartWr)); // R4
  AST_SINGLE_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    changeUsed |=> $stable(rateSel)); // R5
  AST_NO_FAST_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |-> !rdFastTiming); // R7
  AST_CFG_ERR_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !coreRun); // R8
  AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    earlyRestart |=> earlyRestart); // R9
  AST_NO_RESERVED_SEL: assert property (@(posedge clk) disable iff (!rstN)
    !rateSel[1]); // R10

endmodule

bind clk_mult_setup clk_mult_setup_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SETUP_ADDR(SETUP_ADDR),
  .CMD_ADDR(CMD_ADDR), .RESTART_CMD(RESTART_CMD)
) chk_i (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
  .hostWrData(hostWrData), .mulLock(mulLock), .mulEnable(mulEnable),
  .coreRun(coreRun), .rateSel(rateSel), .rdFastTiming(rdFastTiming),
  .cfgErr(cfgErr), .earlyRestart(earlyRestart), .halted(halted),
  .changeUsed(changeUsed)
);

// File: tb/clk_mult_setup_tb_top.sv
`timescale 1ns/1ps
module clk_mult_setup_tb_top;

  localparam int LOCK_DLY = 20;
  localparam int WDOG_MAX = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWrEn = 1'b0;
  logic       hostRdEn = 1'b0;
  logic [1:0] hostAddr = '0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic       mulLock = 1'b0;
  logic       mulEnable, coreRun, enhOn, noSyncOn, rdFastTiming, cfgErr, earlyRestart;
  logic [1:0] rateSel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_mult_setup dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .mulLock(mulLock), .mulEnable(mulEnable), .coreRun(coreRun),
    .rateSel(rateSel), .enhOn(enhOn), .noSyncOn(noSyncOn),
    .rdFastTiming(rdFastTiming), .cfgErr(cfgErr), .earlyRestart(earlyRestart)
  );

  // Behavioural multiplier lock model
  int lockCnt = 0;
  always @(posedge clk) begin
    if (!mulEnable) begin
      lockCnt <= 0;
      mulLock <= 1'b0;
    end else if (lockCnt < LOCK_DLY) begin
      lockCnt <= lockCnt + 1;
    end else begin
      mulLock <= 1'b1;
    end
  end

  // Reference model, written from the requirements
  logic [1:0] mSel;
  bit mEnh, mNoSync, mFast, mUsed, mHalt, mMul, mEarly;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSel <= 2'b00; mEnh <= 0; mNoSync <= 0; mFast <= 0;
      mUsed <= 0; mHalt <= 0; mMul <= 0; mEarly <= 0;
    end else if (hostWrEn) begin
      if (hostAddr == 2'd1) begin
        mEnh <= hostWrData[2]; mNoSync <= hostWrData[3]; mFast <= hostWrData[4];
        if (hostWrData[1] == 1'b0 && hostWrData[1:0] != mSel && !mUsed) begin
          mSel <= hostWrData[1:0]; mUsed <= 1; mHalt <= 1;
          mMul <= (hostWrData[1:0] != 2'b00);
        end
      end else if (hostAddr == 2'd0 && hostWrData == 8'h18 && mHalt) begin
        if (mulLock) mHalt <= 0;
        else         mEarly <= 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chkEq(input int act, input int exp, input string tag);
    chk(act == exp, tag, act, exp);
  endtask

  // Per-cycle comparison against the model, away from the clock edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && !done) begin
      bit expCfg;
      bit expRun;
      logic [7:0] expRd;
      expCfg = (mSel == 2'b01) && !mEnh;
      expRun = !mHalt && !expCfg;
      expRd  = (hostRdEn && hostAddr == 2'd1) ? {3'b000, mFast, mNoSync, mEnh, mSel} : 8'h00;
      chkEq(int'(coreRun), int'(expRun), "R3 model coreRun");
      chkEq(int'(mulEnable), int'(mMul), "R2 model mulEnable");
      chkEq(int'(rateSel), int'(mSel), "R5 model rateSel");
      chkEq(int'(cfgErr), int'(expCfg), "R8 model cfgErr");
      chkEq(int'(earlyRestart), int'(mEarly), "R9 model earlyRestart");
      chkEq(int'(rdFastTiming), int'(mFast && hostRdEn && !hostWrEn), "R7 model rdFastTiming");
      chkEq(int'(hostRdData), int'(expRd), "R6 model hostRdData");
      chkEq(int'({enhOn, noSyncOn}), int'({mEnh, mNoSync}), "R6 model mode bits");
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_MAX && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WDOG_MAX);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #2;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = 8'h00;
    #2;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d, output logic fast);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    #2;
    d = hostRdData; fast = rdFastTiming;
    @(negedge clk);
    hostRdEn = 1'b0;
    #2;
  endtask

  task automatic waitLock();
    while (!mulLock) @(negedge clk);
    @(negedge clk);
    #2;
  endtask

  initial begin
    logic [7:0] rd;
    logic fastSeen;

    // Scenario A
    doReset();
    chkEq(int'({coreRun, mulEnable, rateSel}), 4'b1000, "R1 reset run/mul/sel");
    chkEq(int'({enhOn, noSyncOn, cfgErr, earlyRestart}), 0, "R1 reset flags");
    rdReg(2'd1, rd, fastSeen);
    chkEq(int'(rd), 0, "R1 reset readback");
    chkEq(int'(fastSeen), 0, "R1 reset rdFastTiming");

    wrReg(2'd1, 8'h1C);                         // same select, all mode bits set
    chkEq(int'(coreRun), 1, "R11 same select keeps core running");
    chkEq(int'({enhOn, noSyncOn}), 3, "R6 mode bits loaded");
    rdReg(2'd1, rd, fastSeen);
    chkEq(int'(rd), 8'h1C, "R6 setup readback");
    chkEq(int'(fastSeen), 1, "R7 fast timing on read");
    rdReg(2'd0, rd, fastSeen);
    chkEq(int'(rd), 0, "R6 other address reads zero");

    // write with read strobe also present
    @(negedge clk);
    hostWrEn = 1'b1; hostRdEn = 1'b1; hostAddr = 2'd1; hostWrData = 8'h1C;
    #2;
    chkEq(int'(rdFastTiming), 0, "R7 no fast timing during write");
    @(negedge clk);
    hostWrEn = 1'b0; hostRdEn = 1'b0;
    #2;

    wrReg(2'd1, 8'h1E);                         // reserved code 10
    chkEq(int'(rateSel), 0, "R10 reserved code ignored");
    chkEq(int'(coreRun), 1, "R10 reserved code no halt");
    wrReg(2'd1, 8'h1F);                         // reserved code 11
    chkEq(int'(rateSel), 0, "R10 reserved code 11 ignored");

    wrReg(2'd1, 8'h1D);                         // change to 01, enhanced on
    chkEq(int'(coreRun), 0, "R3 change halts core");
    chkEq(int'(mulEnable), 1, "R2 multiplier woken");
    chkEq(int'(rateSel), 1, "R11 change still available after rejects");

    wrReg(2'd0, 8'h18);                         // before lock
    chkEq(int'(coreRun), 0, "R9 early restart ignored");
    chkEq(int'(earlyRestart), 1, "R9 early flag set");

    waitLock();
    wrReg(2'd0, 8'h17);
    chkEq(int'(coreRun), 0, "R12 wrong command ignored");
    wrReg(2'd0, 8'h18);
    chkEq(int'(coreRun), 1, "R4 locked restart runs core");
    chkEq(int'(earlyRestart), 1, "R9 early flag sticky");
    wrReg(2'd0, 8'h18);
    chkEq(int'(coreRun), 1, "R12 restart while running no effect");

    wrReg(2'd1, 8'h1C);                         // try to go back to 00
    chkEq(int'(rateSel), 1, "R5 second change ignored");
    chkEq(int'(coreRun), 1, "R5 second change no halt");

    // Scenario B: configuration error
    doReset();
    chkEq(int'(earlyRestart), 0, "R1 early flag cleared by reset");
    wrReg(2'd1, 8'h01);
    chkEq(int'(cfgErr), 1, "R8 double rate without enhanced");
    chkEq(int'(coreRun), 0, "R8 core halted");
    waitLock();
    wrReg(2'd0, 8'h18);
    chkEq(int'(coreRun), 0, "R8 restart cannot override cfgErr");
    chkEq(int'(earlyRestart), 0, "R4 locked restart not early");
    wrReg(2'd1, 8'h05);
    chkEq(int'(cfgErr), 0, "R8 cfgErr clears with enhanced");
    chkEq(int'(coreRun), 1, "R8 core runs once config valid");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule